// File: doc/BRIEF.md
# CAN fault confinement state classifier

This block turns a snapshot of a CAN controller's fault confinement information into a registered error state. It also produces the events that follow from that state. On each sample strobe it reads five things: an error-flag byte, a status byte, the transmit and receive error counters, and a bus-error interrupt indication. From these it decides whether the node is error-active, error-warning, error-passive or bus-off. When the state moves, it pulses a change event and records which side the new state belongs to: transmit, receive or both.

In the same sampled cycle, it can also report one protocol-error cause as a one-hot vector that is valid for a single cycle. This happens only when the bus-error interrupt is present, reporting is enabled and a protocol error flag is set. If the node enters bus-off while automatic restart is off, the block raises a sticky sleep request and stops evaluating samples until reset. The counters and flags come from outside. This block only classifies them.

Top module: `can_fc_classifier`

## Requirements
- R1: The state code on `state_o` is 3 (bus-off) when error-flag bit 7 is set; otherwise 2 (passive) when bit 6 or bit 5 is set; otherwise 1 (warning) when status bit 4 is set; otherwise 0 (active).
- R2: The state is loaded only in a cycle where `sample_i` is high, and it appears on `state_o` one clock later. With `sample_i` low, every output other than the pulses keeps its value.
- R3: `change_o` is high for exactly the one cycle after a sample whose computed state differs from the registered state. A sample that yields the same state gives no pulse.
- R4: On a change, `tx_state_o` takes the new state when the transmit counter is greater than or equal to the receive counter, and otherwise becomes 0. `rx_state_o` takes the new state when the transmit counter is less than or equal to the receive counter, and otherwise becomes 0. Both values hold until the next change.
- R5: `cause_valid_o` pulses one cycle after a sample only when `bus_err_irq_i`, `report_en_i` and at least one of error-flag bits 4..0 are all high. Otherwise `cause_o` is 0.
- R6: The cause is the first set flag in the order bit error (flag bit 4), form (bit 3), stuff (bit 0), CRC (bit 2), ack (bit 1). It is encoded one-hot on `cause_o` as bit 0 for bit error, bit 1 for form, bit 2 for stuff, bit 3 for CRC and bit 4 for ack.
- R7: A change into bus-off with `auto_restart_i` low sets `sleep_req_o`, which stays high until reset. A change into bus-off with `auto_restart_i` high leaves it low.
- R8: While `sleep_req_o` is high, samples are ignored: the state, the side states and both pulses do not change.
- R9: After reset, `state_o`, `tx_state_o` and `rx_state_o` are 0 and `change_o`, `cause_valid_o`, `cause_o` and `sleep_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | Evaluate the inputs in this cycle |
| err_flags_i | input | 8 | Error-flag byte |
| status_i | input | 8 | Status byte; bit 4 is the warning flag |
| tec_i | input | CNT_W | Transmit error counter |
| rec_i | input | CNT_W | Receive error counter |
| bus_err_irq_i | input | 1 | Bus-error interrupt present |
| report_en_i | input | 1 | Protocol-error reporting enabled |
| auto_restart_i | input | 1 | Automatic bus-off restart enabled |
| state_o | output | 2 | Registered error state |
| change_o | output | 1 | One-cycle state change pulse |
| tx_state_o | output | 2 | State attributed to the transmit side |
| rx_state_o | output | 2 | State attributed to the receive side |
| cause_valid_o | output | 1 | One-cycle protocol cause valid |
| cause_o | output | 5 | One-hot protocol-error cause |
| sleep_req_o | output | 1 | Sticky sleep request after bus-off without restart |

## Verification
The hardest case to reach is the halted condition. It needs a real transition into bus-off with automatic restart off, and only reset can undo it. The stimulus therefore runs every other case first: it walks the states, moves through bus-off with restart on, and returns to active. Only at the end does it enter bus-off without restart and then keep sampling with inputs that would otherwise change the state and raise causes. Counter ties are also driven on purpose, so that both side outputs take the new state in the same change.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_WARNING = 2'd1,
        FC_PASSIVE = 2'd2,
        FC_BUSOFF  = 2'd3
    } fc_state_e;

    localparam int FLAG_W    = 8;
    localparam int CAUSE_N   = 5;

    localparam int EF_BUSOFF = 7;
    localparam int EF_TXPASS = 6;
    localparam int EF_RXPASS = 5;
    localparam int ST_WARN   = 4;

    // protocol flag positions, listed from highest to lowest priority
    localparam int EF_BIT    = 4;
    localparam int EF_FORM   = 3;
    localparam int EF_STUFF  = 0;
    localparam int EF_CRC    = 2;
    localparam int EF_ACK    = 1;

    function automatic int cause_src(input int k);
        case (k)
            0:       return EF_BIT;
            1:       return EF_FORM;
            2:       return EF_STUFF;
            3:       return EF_CRC;
            default: return EF_ACK;
        endcase
    endfunction

endpackage

// File: rtl/can_fc_state.sv
module can_fc_state
    import can_fc_pkg::*;
(
    input  logic [FLAG_W-1:0] err_flags_i,
    input  logic [FLAG_W-1:0] status_i,
    output fc_state_e         state_o
);
    logic unused_status;
    assign unused_status = ^{status_i[FLAG_W-1:ST_WARN+1], status_i[ST_WARN-1:0]};

    always_comb begin
        if (err_flags_i[EF_BUSOFF])
            state_o = FC_BUSOFF;
        else if (err_flags_i[EF_TXPASS] || err_flags_i[EF_RXPASS])
            state_o = FC_PASSIVE;
        else if (status_i[ST_WARN])
            state_o = FC_WARNING;
        else
            state_o = FC_ACTIVE;
    end
endmodule

// File: rtl/can_fc_cause.sv
module can_fc_cause
    import can_fc_pkg::*;
(
    input  logic [FLAG_W-1:0]  err_flags_i,
    output logic               any_o,
    output logic [CAUSE_N-1:0] cause_o
);
    logic [CAUSE_N:0] taken;

    assign taken[0] = 1'b0;

    genvar k;
    generate
        for (k = 0; k < CAUSE_N; k++) begin : g_prio
            localparam int SRC = cause_src(k);
            assign cause_o[k]  = err_flags_i[SRC] & ~taken[k];
            assign taken[k+1]  = taken[k] | err_flags_i[SRC];
        end
    endgenerate

    assign any_o = taken[CAUSE_N];
endmodule

// File: rtl/can_fc_attrib.sv
module can_fc_attrib
    import can_fc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] tec_i,
    input  logic [CNT_W-1:0] rec_i,
    input  fc_state_e        new_state_i,
    output fc_state_e        tx_state_o,
    output fc_state_e        rx_state_o
);
    logic tx_takes;
    logic rx_takes;

    assign tx_takes   = (tec_i >= rec_i);
    assign rx_takes   = (tec_i <= rec_i);
    assign tx_state_o = tx_takes ? new_state_i : FC_ACTIVE;
    assign rx_state_o = rx_takes ? new_state_i : FC_ACTIVE;
endmodule

// File: rtl/can_fc_classifier.sv
module can_fc_classifier
    import can_fc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_i,
    input  logic [7:0]         err_flags_i,
    input  logic [7:0]         status_i,
    input  logic [CNT_W-1:0]   tec_i,
    input  logic [CNT_W-1:0]   rec_i,
    input  logic               bus_err_irq_i,
    input  logic               report_en_i,
    input  logic               auto_restart_i,
    output logic [1:0]         state_o,
    output logic               change_o,
    output logic [1:0]         tx_state_o,
    output logic [1:0]         rx_state_o,
    output logic               cause_valid_o,
    output logic [4:0]         cause_o,
    output logic               sleep_req_o
);
    typedef struct packed {
        fc_state_e          state;
        logic               change;
        fc_state_e          tx_st;
        fc_state_e          rx_st;
        logic               cause_vld;
        logic [CAUSE_N-1:0] cause;
        logic               halted;
    } fc_regs_t;

    localparam fc_regs_t REGS_RST = '{
        state:     FC_ACTIVE,
        change:    1'b0,
        tx_st:     FC_ACTIVE,
        rx_st:     FC_ACTIVE,
        cause_vld: 1'b0,
        cause:     '0,
        halted:    1'b0
    };

    fc_regs_t regs_d, regs_q;

    fc_state_e          cls_state;
    fc_state_e          side_tx;
    fc_state_e          side_rx;
    logic               cause_any;
    logic [CAUSE_N-1:0] cause_oh;

    can_fc_state u_state (
        .err_flags_i (err_flags_i),
        .status_i    (status_i),
        .state_o     (cls_state)
    );

    can_fc_cause u_cause (
        .err_flags_i (err_flags_i),
        .any_o       (cause_any),
        .cause_o     (cause_oh)
    );

    can_fc_attrib #(.CNT_W(CNT_W)) u_attrib (
        .tec_i       (tec_i),
        .rec_i       (rec_i),
        .new_state_i (cls_state),
        .tx_state_o  (side_tx),
        .rx_state_o  (side_rx)
    );

    always_comb begin
        regs_d           = regs_q;
        regs_d.change    = 1'b0;
        regs_d.cause_vld = 1'b0;
        regs_d.cause     = '0;
        if (sample_i && !regs_q.halted) begin
            regs_d.state = cls_state;
            if (cls_state != regs_q.state) begin
                regs_d.change = 1'b1;
                regs_d.tx_st  = side_tx;
                regs_d.rx_st  = side_rx;
                if (cls_state == FC_BUSOFF && !auto_restart_i)
                    regs_d.halted = 1'b1;
            end
            if (bus_err_irq_i && report_en_i && cause_any) begin
                regs_d.cause_vld = 1'b1;
                regs_d.cause     = cause_oh;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            regs_q <= REGS_RST;
        else
            regs_q <= regs_d;
    end

    assign state_o       = regs_q.state;
    assign change_o      = regs_q.change;
    assign tx_state_o    = regs_q.tx_st;
    assign rx_state_o    = regs_q.rx_st;
    assign cause_valid_o = regs_q.cause_vld;
    assign cause_o       = regs_q.cause;
    assign sleep_req_o   = regs_q.halted;
endmodule

// File: rtl/can_fc_classifier_chk.sv
module can_fc_classifier_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] state_o,
    input logic       change_o,
    input logic [1:0] tx_state_o,
    input logic [1:0] rx_state_o,
    input logic       cause_valid_o,
    input logic [4:0] cause_o,
    input logic       sleep_req_o
);
    assert_change_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        change_o |-> state_o != $past(state_o));

    assert_side_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        change_o |-> (tx_state_o == state_o || rx_state_o == state_o));

    assert_cause_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_valid_o |-> cause_o == 5'd0);

    assert_cause_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cause_valid_o |-> $countones(cause_o) == 1);

    assert_sleep_busoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req_o |-> state_o == 2'd3);

    assert_sleep_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req_o |=> sleep_req_o);

    assert_halt_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req_o |=> ($stable(state_o) && $stable(tx_state_o) && $stable(rx_state_o)
                         && !change_o && !cause_valid_o));
endmodule

bind can_fc_classifier can_fc_classifier_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_o       (state_o),
    .change_o      (change_o),
    .tx_state_o    (tx_state_o),
    .rx_state_o    (rx_state_o),
    .cause_valid_o (cause_valid_o),
    .cause_o       (cause_o),
    .sleep_req_o   (sleep_req_o)
);

// File: tb/can_fc_classifier_tb.sv
`timescale 1ns/1ps
module can_fc_classifier_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_i = 1'b0;
    logic [7:0] err_flags_i = '0;
    logic [7:0] status_i = '0;
    logic [7:0] tec_i = '0;
    logic [7:0] rec_i = '0;
    logic       bus_err_irq_i = 1'b0;
    logic       report_en_i = 1'b0;
    logic       auto_restart_i = 1'b0;
    logic [1:0] state_o;
    logic       change_o;
    logic [1:0] tx_state_o;
    logic [1:0] rx_state_o;
    logic       cause_valid_o;
    logic [4:0] cause_o;
    logic       sleep_req_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    int m_state, m_tx, m_rx, m_halt;
    int e_change, e_cvld, e_cause;

    always #5 clk = ~clk;

    can_fc_classifier u_dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_state = 0; m_tx = 0; m_rx = 0; m_halt = 0;
        e_change = 0; e_cvld = 0; e_cause = 0;
    endtask

    task automatic compare_all();
        chk("R1/R2 state", state_o, m_state);
        chk("R3 change", change_o, e_change);
        chk("R4 tx side", tx_state_o, m_tx);
        chk("R4 rx side", rx_state_o, m_rx);
        chk("R5 cause valid", cause_valid_o, e_cvld);
        chk("R6 cause", cause_o, e_cause);
        chk("R7/R8 sleep", sleep_req_o, m_halt);
    endtask

    // drive one cycle of inputs (called at a falling edge), update model, compare
    task automatic step(input bit s, input int ef, input int st, input int t, input int r,
                        input bit irq, input bit rep, input bit ar);
        int ns;
        sample_i = s; err_flags_i = ef[7:0]; status_i = st[7:0];
        tec_i = t[7:0]; rec_i = r[7:0];
        bus_err_irq_i = irq; report_en_i = rep; auto_restart_i = ar;
        e_change = 0; e_cvld = 0; e_cause = 0;
        if (s && m_halt == 0) begin
            if (ef & 8'h80)      ns = 3;
            else if (ef & 8'h60) ns = 2;
            else if (st & 8'h10) ns = 1;
            else                 ns = 0;
            if (ns != m_state) begin
                e_change = 1;
                m_tx = (t >= r) ? ns : 0;
                m_rx = (t <= r) ? ns : 0;
                if (ns == 3 && !ar) m_halt = 1;
            end
            m_state = ns;
            if (irq && rep && (ef & 8'h1f) != 0) begin
                e_cvld = 1;
                if (ef & 8'h10)      e_cause = 1;
                else if (ef & 8'h08) e_cause = 2;
                else if (ef & 8'h01) e_cause = 4;
                else if (ef & 8'h04) e_cause = 8;
                else                 e_cause = 16;
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sample_i = 0;
        model_reset();
        @(negedge clk); @(negedge clk);
        compare_all();            // R9 reset values
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        model_reset();
        do_reset();
        // R1 walk through states, R4 side attribution
        step(1, 8'h00, 8'h10, 10, 20, 0, 0, 1);   // warning, rx side only
        step(1, 8'h00, 8'h10, 10, 20, 0, 0, 1);   // R3 same state, no pulse
        step(1, 8'h40, 8'h10, 90, 30, 0, 0, 1);   // passive, tx side only
        step(1, 8'h20, 8'h00, 50, 50, 0, 0, 1);   // passive again, no change
        step(0, 8'h80, 8'h00, 0, 0, 0, 0, 1);     // R2 no sample, held
        step(1, 8'h00, 8'h00, 5, 5, 0, 0, 1);     // active, tie
        step(1, 8'h60, 8'h10, 7, 7, 0, 0, 1);     // passive, R4 tie: both sides
        step(1, 8'h80, 8'h10, 200, 3, 0, 0, 1);   // R7 bus-off with restart: no sleep
        step(1, 8'h80, 8'h00, 200, 3, 0, 0, 0);   // same state: no sleep either
        step(1, 8'h00, 8'h10, 0, 0, 0, 0, 1);     // bus-off -> warning
        step(1, 8'h00, 8'h00, 0, 1, 0, 0, 1);     // active
        // R5 gating and R6 priority
        step(1, 8'h1f, 8'h00, 0, 0, 1, 1, 1);     // bit error wins
        step(1, 8'h0f, 8'h00, 0, 0, 1, 1, 1);     // form wins
        step(1, 8'h07, 8'h00, 0, 0, 1, 1, 1);     // stuff over CRC and ack
        step(1, 8'h06, 8'h00, 0, 0, 1, 1, 1);     // CRC over ack
        step(1, 8'h02, 8'h00, 0, 0, 1, 1, 1);     // ack only
        step(1, 8'h01, 8'h00, 0, 0, 1, 1, 1);     // stuff only
        step(1, 8'h1f, 8'h00, 0, 0, 1, 0, 1);     // R5 reporting off
        step(1, 8'h1f, 8'h00, 0, 0, 0, 1, 1);     // R5 no interrupt
        step(1, 8'he0, 8'h10, 9, 4, 1, 1, 1);     // R5 no protocol flag, bus-off
        step(0, 8'h1f, 8'h00, 0, 0, 1, 1, 1);     // R2 unsampled cause ignored
        step(1, 8'h48, 8'h00, 3, 4, 1, 1, 1);     // passive with form cause same cycle
        step(1, 8'h00, 8'h00, 0, 0, 0, 0, 1);     // active
        // R7 bus-off without restart, cause in same sample still reported
        step(1, 8'h90, 8'h00, 255, 10, 1, 1, 0);
        // R8 halted: further samples ignored
        step(1, 8'h00, 8'h00, 0, 0, 0, 0, 1);
        step(1, 8'h5f, 8'h10, 1, 2, 1, 1, 1);
        step(1, 8'h00, 8'h10, 0, 0, 1, 1, 0);
        // R9 reset clears halt
        do_reset();
        step(1, 8'h00, 8'h10, 3, 3, 0, 0, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule